// File: doc/BRIEF.md
# GPIO Port Direction Override Logic

This block controls an 8-pin general-purpose I/O port. Software sets each pin's direction through a direction register and sets each pin's output level through a data register. Both registers sit on a simple strobe-based register bus. From the direction bit and from requests raised by three neighbouring peripherals, the block works out an effective mode for each pin. It then drives three controls to each pad: output enable, input enable and open-drain select.

There are three override sources, in fixed priority order:

- A segment-display driver enable, which can switch upper pins fully off.
- A two-wire serial bus that is routed to this port and enabled, which turns two pins into open-drain outputs.
- Timer output-compare channels that are routed to this port, which force two low pins to drive.

When no override is active, a pin follows its direction bit. Reading the data address returns pin readback. For pins in an output mode, the readback is the written data bit. For pins in input mode, it is the synchronized pad level. For pins that are switched off, it is zero.

Top module: `gpio_ovr_port`

## Requirements
- R1: After reset the direction and data registers are 0x00, and every pin has output enable 0, input enable 1 and open-drain select 0.
- R2: The direction register is at offset 0x282 and can be read and written at any time. A write takes effect at the next clock edge. A read in the same cycle as a write to it returns the value from before the write.
- R3: The data register is at offset 0x280. A write there updates `pin_do` at the next clock edge.
- R4: While `seg_en[i]` is 1 for a pin i in 7..4, that pin has output enable, input enable and open-drain select all 0, whatever the other overrides and the direction bit say. `seg_en` bits 3..0 have no effect.
- R5: On pins 6 and 5, when the R4 override is not active and both `ser_route` and `ser_en` are 1, the pin gets output enable 1, open-drain select 1 and input enable 1. If either of those two inputs is 0, the serial override has no effect.
- R6: On pins 3 and 2, when `tmr_route` is 1 and `tmr_oc_en[i]` is 1, the pin gets output enable 1 and open-drain select 0, whatever its direction bit. `tmr_oc_en` bits on other pins have no effect.
- R7: A pin with no active override has output enable equal to its direction bit, input enable 1 and open-drain select 0.
- R8: A read of offset 0x280 returns, per bit, the data register bit if the pin's output enable is 1, else the synchronized pad bit if its input enable is 1, else 0.
- R9: The pad input passes through two flip-flops before readback. A pad change made just before a read is not yet visible to that read, and it is visible to a read issued two cycles later.
- R10: A read of any other offset returns 0x00. A write to any other offset changes no register.
- R11: `rd_data` carries the read result in the cycle after `rd_stb`, and is 0x00 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle write strobe |
| rd_stb | input | 1 | One-cycle read strobe |
| addr | input | 10 | Register offset |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid the cycle after `rd_stb` |
| seg_en | input | 8 | Segment-display driver enable, one bit per pin |
| ser_route | input | 1 | Serial bus is routed to this port |
| ser_en | input | 1 | Serial bus is enabled |
| tmr_route | input | 1 | Timer channels are routed to this port |
| tmr_oc_en | input | 8 | Output-compare enable, one bit per pin |
| pad_in | input | 8 | Raw pad input levels |
| pin_do | output | 8 | Data register value sent to the pads |
| pin_oe | output | 8 | Pad output enable |
| pin_ie | output | 8 | Pad input enable |
| pin_od | output | 8 | Pad open-drain select |

## Verification
A register write and a register read can land in the same cycle. The bench raises the write strobe and the read strobe together at the direction offset. The scoreboard expects the old direction value for that read, and a following read must return the new value. Override changes also meet register state on the same pins. The segment enable and the serial routing are raised together on pin 6 to judge the priority order, and data readback is taken while a pin is forced off or forced to drive, so that the mode chosen by the overrides is seen both on the pad controls and in `rd_data`.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;

   // Effective per-pin mode after override resolution
   typedef enum logic [1:0] {
      PM_FOLLOW     = 2'd0,   // direction bit decides
      PM_OFF        = 2'd1,   // input and output both disabled
      PM_OPEN_DRAIN = 2'd2,   // forced open-drain output
      PM_DRIVE      = 2'd3    // forced push-pull output
   } pin_mode_e;

   typedef struct packed {
      logic oe;
      logic ie;
      logic od;
   } pad_ctl_t;

   function automatic pad_ctl_t mode_to_ctl(input pin_mode_e mode, input logic dir_bit);
      pad_ctl_t c;
      unique case (mode)
         PM_OFF:        c = '{oe: 1'b0,    ie: 1'b0, od: 1'b0};
         PM_OPEN_DRAIN: c = '{oe: 1'b1,    ie: 1'b1, od: 1'b1};
         PM_DRIVE:      c = '{oe: 1'b1,    ie: 1'b1, od: 1'b0};
         default:       c = '{oe: dir_bit, ie: 1'b1, od: 1'b0};
      endcase
      return c;
   endfunction

endpackage

// File: rtl/gpio_ovr_arbiter.sv
module gpio_ovr_arbiter
   import gpio_ovr_pkg::*;
#(
   parameter int unsigned     PIN_W    = 8,
   parameter logic [PIN_W-1:0] SEG_MASK = 8'hF0,
   parameter logic [PIN_W-1:0] SER_MASK = 8'h60,
   parameter logic [PIN_W-1:0] TMR_MASK = 8'h0C
) (
   input  logic [PIN_W-1:0] dir_q,
   input  logic [PIN_W-1:0] seg_en,
   input  logic             ser_route,
   input  logic             ser_en,
   input  logic             tmr_route,
   input  logic [PIN_W-1:0] tmr_oc_en,
   output logic [PIN_W-1:0] pin_oe,
   output logic [PIN_W-1:0] pin_ie,
   output logic [PIN_W-1:0] pin_od
);

   // Requests limited to the pins each peripheral can reach
   logic [PIN_W-1:0] seg_req;
   logic [PIN_W-1:0] ser_req;
   logic [PIN_W-1:0] tmr_req;

   assign seg_req = seg_en & SEG_MASK;
   assign ser_req = {PIN_W{ser_route & ser_en}} & SER_MASK;
   assign tmr_req = {PIN_W{tmr_route}} & tmr_oc_en & TMR_MASK;

   for (genvar i = 0; i < PIN_W; i++) begin : g_pin
      localparam bit HAS_OVR = SEG_MASK[i] | SER_MASK[i] | TMR_MASK[i];
      pin_mode_e mode;
      pad_ctl_t  ctl;

      if (HAS_OVR) begin : g_ovr
         // Fixed priority: display off, then serial open-drain, then timer drive
         always_comb begin
            if (seg_req[i])      mode = PM_OFF;
            else if (ser_req[i]) mode = PM_OPEN_DRAIN;
            else if (tmr_req[i]) mode = PM_DRIVE;
            else                 mode = PM_FOLLOW;
         end
      end else begin : g_plain
         assign mode = PM_FOLLOW;
      end

      assign ctl       = mode_to_ctl(mode, dir_q[i]);
      assign pin_oe[i] = ctl.oe;
      assign pin_ie[i] = ctl.ie;
      assign pin_od[i] = ctl.od;
   end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs #(
   parameter int unsigned PIN_W    = 8,
   parameter int unsigned ADDR_W   = 10,
   parameter int unsigned DIR_OFS  = 'h282,
   parameter int unsigned DATA_OFS = 'h280
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic              rd_stb,
   input  logic [ADDR_W-1:0] addr,
   input  logic [PIN_W-1:0]  wdata,
   input  logic [PIN_W-1:0]  pin_oe,
   input  logic [PIN_W-1:0]  pin_ie,
   input  logic [PIN_W-1:0]  pad_sync,
   output logic [PIN_W-1:0]  dir_q,
   output logic [PIN_W-1:0]  data_q,
   output logic [PIN_W-1:0]  rd_data
);

   localparam logic [ADDR_W-1:0] DIR_A  = ADDR_W'(DIR_OFS);
   localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);

   logic hit_dir;
   logic hit_data;
   logic [PIN_W-1:0] readback;
   logic [PIN_W-1:0] rd_mux;

   assign hit_dir  = (addr == DIR_A);
   assign hit_data = (addr == DATA_A);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         data_q <= '0;
      end else if (wr_stb) begin
         if (hit_dir)  dir_q  <= wdata;
         if (hit_data) data_q <= wdata;
      end
   end

   // Per-pin readback chosen by the effective pad mode
   for (genvar i = 0; i < PIN_W; i++) begin : g_rb
      always_comb begin
         if (pin_oe[i])      readback[i] = data_q[i];
         else if (pin_ie[i]) readback[i] = pad_sync[i];
         else                readback[i] = 1'b0;
      end
   end

   always_comb begin
      rd_mux = '0;
      if (hit_dir)       rd_mux = dir_q;
      else if (hit_data) rd_mux = readback;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rd_data <= '0;
      else if (rd_stb) rd_data <= rd_mux;
      else             rd_data <= '0;
   end

endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port #(
   parameter int unsigned      PIN_W     = 8,
   parameter int unsigned      ADDR_W    = 10,
   parameter int unsigned      DIR_OFS   = 'h282,
   parameter int unsigned      DATA_OFS  = 'h280,
   parameter int unsigned      SYNC_STG  = 2,
   parameter logic [PIN_W-1:0] SEG_MASK  = 8'hF0,
   parameter logic [PIN_W-1:0] SER_MASK  = 8'h60,
   parameter logic [PIN_W-1:0] TMR_MASK  = 8'h0C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic              rd_stb,
   input  logic [ADDR_W-1:0] addr,
   input  logic [PIN_W-1:0]  wdata,
   output logic [PIN_W-1:0]  rd_data,
   input  logic [PIN_W-1:0]  seg_en,
   input  logic              ser_route,
   input  logic              ser_en,
   input  logic              tmr_route,
   input  logic [PIN_W-1:0]  tmr_oc_en,
   input  logic [PIN_W-1:0]  pad_in,
   output logic [PIN_W-1:0]  pin_do,
   output logic [PIN_W-1:0]  pin_oe,
   output logic [PIN_W-1:0]  pin_ie,
   output logic [PIN_W-1:0]  pin_od
);

   // Elaboration-time parameter checks
   if (PIN_W < 1 || PIN_W > 32) begin : g_bad_width
      $error("gpio_ovr_port: PIN_W out of range");
   end
   if (DIR_OFS == DATA_OFS) begin : g_bad_ofs
      $error("gpio_ovr_port: register offsets collide");
   end
   if (DIR_OFS >= (1 << ADDR_W) || DATA_OFS >= (1 << ADDR_W)) begin : g_bad_addr
      $error("gpio_ovr_port: offset does not fit ADDR_W");
   end

   logic [PIN_W-1:0] dir_q;
   logic [PIN_W-1:0] data_q;
   logic [PIN_W-1:0] pad_sync;

   gpio_in_sync #(
      .WIDTH  (PIN_W),
      .STAGES (SYNC_STG)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pad_sync)
   );

   gpio_ovr_arbiter #(
      .PIN_W    (PIN_W),
      .SEG_MASK (SEG_MASK),
      .SER_MASK (SER_MASK),
      .TMR_MASK (TMR_MASK)
   ) u_arb (
      .dir_q     (dir_q),
      .seg_en    (seg_en),
      .ser_route (ser_route),
      .ser_en    (ser_en),
      .tmr_route (tmr_route),
      .tmr_oc_en (tmr_oc_en),
      .pin_oe    (pin_oe),
      .pin_ie    (pin_ie),
      .pin_od    (pin_od)
   );

   gpio_ovr_regs #(
      .PIN_W    (PIN_W),
      .ADDR_W   (ADDR_W),
      .DIR_OFS  (DIR_OFS),
      .DATA_OFS (DATA_OFS)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_stb   (wr_stb),
      .rd_stb   (rd_stb),
      .addr     (addr),
      .wdata    (wdata),
      .pin_oe   (pin_oe),
      .pin_ie   (pin_ie),
      .pad_sync (pad_sync),
      .dir_q    (dir_q),
      .data_q   (data_q),
      .rd_data  (rd_data)
   );

   assign pin_do = data_q;

endmodule

// File: rtl/gpio_ovr_port_chk.sv
module gpio_ovr_port_chk #(
   parameter int unsigned      PIN_W    = 8,
   parameter int unsigned      ADDR_W   = 10,
   parameter int unsigned      DIR_OFS  = 'h282,
   parameter int unsigned      DATA_OFS = 'h280,
   parameter logic [PIN_W-1:0] SEG_MASK = 8'hF0,
   parameter logic [PIN_W-1:0] SER_MASK = 8'h60,
   parameter logic [PIN_W-1:0] TMR_MASK = 8'h0C
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_stb,
   input logic              rd_stb,
   input logic [ADDR_W-1:0] addr,
   input logic [PIN_W-1:0]  wdata,
   input logic [PIN_W-1:0]  rd_data,
   input logic [PIN_W-1:0]  seg_en,
   input logic              ser_route,
   input logic              ser_en,
   input logic              tmr_route,
   input logic [PIN_W-1:0]  tmr_oc_en,
   input logic [PIN_W-1:0]  pin_oe,
   input logic [PIN_W-1:0]  pin_ie,
   input logic [PIN_W-1:0]  pin_od,
   input logic [PIN_W-1:0]  dir_q,
   input logic [PIN_W-1:0]  data_q
);

   localparam logic [ADDR_W-1:0] DIR_A  = ADDR_W'(DIR_OFS);
   localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);

   logic [PIN_W-1:0] seg_on;
   logic [PIN_W-1:0] any_ovr;
   assign seg_on  = seg_en & SEG_MASK;
   assign any_ovr = seg_on
                  | ({PIN_W{ser_route & ser_en}} & SER_MASK)
                  | ({PIN_W{tmr_route}} & tmr_oc_en & TMR_MASK);

   assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && addr == DIR_A) |=> (dir_q == $past(wdata)));

   assert_data_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && addr == DATA_A) |=> (data_q == $past(wdata)));

   assert_seg_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (((pin_oe | pin_ie | pin_od) & seg_on) == '0));

   assert_od_only_serial_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(ser_route && ser_en) |-> (pin_od == '0));

   assert_od_needs_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_od & ~pin_oe) == '0));

   assert_tmr_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_route |-> ((tmr_oc_en & TMR_MASK & ~seg_on & ~pin_oe) == '0));

   assert_follow_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((((pin_oe ^ dir_q) | ~pin_ie | pin_od) & ~any_ovr) == '0));

   assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && addr != DIR_A && addr != DATA_A) |=> (rd_data == '0));

   assert_rd_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> (rd_data == '0));

endmodule

bind gpio_ovr_port gpio_ovr_port_chk #(
   .PIN_W    (PIN_W),
   .ADDR_W   (ADDR_W),
   .DIR_OFS  (DIR_OFS),
   .DATA_OFS (DATA_OFS),
   .SEG_MASK (SEG_MASK),
   .SER_MASK (SER_MASK),
   .TMR_MASK (TMR_MASK)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_stb    (wr_stb),
   .rd_stb    (rd_stb),
   .addr      (addr),
   .wdata     (wdata),
   .rd_data   (rd_data),
   .seg_en    (seg_en),
   .ser_route (ser_route),
   .ser_en    (ser_en),
   .tmr_route (tmr_route),
   .tmr_oc_en (tmr_oc_en),
   .pin_oe    (pin_oe),
   .pin_ie    (pin_ie),
   .pin_od    (pin_od),
   .dir_q     (dir_q),
   .data_q    (data_q)
);

// File: tb/gpio_ovr_port_tb_top.sv
`timescale 1ns/1ps
module gpio_ovr_port_tb_top;

   localparam logic [9:0] A_DIR  = 10'h282;
   localparam logic [9:0] A_DATA = 10'h280;
   localparam logic [9:0] A_GAP  = 10'h281;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_stb = 1'b0;
   logic       rd_stb = 1'b0;
   logic [9:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rd_data;
   logic [7:0] seg_en = '0;
   logic       ser_route = 1'b0;
   logic       ser_en = 1'b0;
   logic       tmr_route = 1'b0;
   logic [7:0] tmr_oc_en = '0;
   logic [7:0] pad_in = '0;
   logic [7:0] pin_do, pin_oe, pin_ie, pin_od;

   int n_chk  = 0;
   int n_fail = 0;
   bit mon_on = 1'b0;
   bit rv_q   = 1'b0;
   logic [7:0] exp_q [$];
   string      tag_q [$];

   always #2 clk = ~clk;   // 250 MHz

   gpio_ovr_port dut_i (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
      .addr(addr), .wdata(wdata), .rd_data(rd_data),
      .seg_en(seg_en), .ser_route(ser_route), .ser_en(ser_en),
      .tmr_route(tmr_route), .tmr_oc_en(tmr_oc_en), .pad_in(pad_in),
      .pin_do(pin_do), .pin_oe(pin_oe), .pin_ie(pin_ie), .pin_od(pin_od)
   );

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   // Monitor: a read result is due the cycle after the strobe
   always @(posedge clk) rv_q <= rd_stb;

   always @(negedge clk) begin
      if (mon_on) begin
         if (rv_q) begin
            if (exp_q.size() == 0) check(rd_data, 8'hxx, "scoreboard empty");
            else check(rd_data, exp_q.pop_front(), tag_q.pop_front());
         end else begin
            check(rd_data, 8'h00, "R11 idle rd_data");
         end
      end
   end

   task automatic do_write(input logic [9:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_stb = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_stb = 1'b0;
   endtask

   task automatic do_read(input logic [9:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      rd_stb = 1'b1; addr = a;
      exp_q.push_back(exp); tag_q.push_back(tag);
      @(negedge clk);
      rd_stb = 1'b0;
   endtask

   task automatic chk_pins(input logic [7:0] oe, input logic [7:0] ie,
                           input logic [7:0] od, input string tag);
      @(negedge clk);
      check(pin_oe, oe, {tag, " oe"});
      check(pin_ie, ie, {tag, " ie"});
      check(pin_od, od, {tag, " od"});
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      mon_on = 1'b1;

      // R1 reset state
      chk_pins(8'h00, 8'hFF, 8'h00, "R1 reset");
      check(pin_do, 8'h00, "R1 data reset");
      do_read(A_DIR, 8'h00, "R1 dir reset");
      do_read(A_DATA, 8'h00, "R1 readback reset");

      // R2 / R7 direction write
      do_write(A_DIR, 8'hA5);
      do_read(A_DIR, 8'hA5, "R2 dir readback");
      chk_pins(8'hA5, 8'hFF, 8'h00, "R7 follow dir");

      // R2 write and read in the same cycle
      @(negedge clk);
      wr_stb = 1'b1; rd_stb = 1'b1; addr = A_DIR; wdata = 8'h3C;
      exp_q.push_back(8'hA5); tag_q.push_back("R2 same-cycle old value");
      @(negedge clk);
      wr_stb = 1'b0; rd_stb = 1'b0;
      do_read(A_DIR, 8'h3C, "R2 new value");

      // R3 data register, R8 mixed readback
      do_write(A_DATA, 8'h96);
      check(pin_do, 8'h96, "R3 pin_do");
      pad_in = 8'h0F;
      repeat (4) @(negedge clk);
      do_read(A_DATA, 8'h17, "R8 mixed readback");

      // R10 unmapped offset
      do_write(A_GAP, 8'hFF);
      do_read(A_DIR, 8'h3C, "R10 dir untouched");
      check(pin_do, 8'h96, "R10 data untouched");
      do_read(A_GAP, 8'h00, "R10 unmapped read");

      // R4 display override, low seg_en bits ignored
      @(negedge clk); seg_en = 8'hFF;
      chk_pins(8'h0C, 8'h0F, 8'h00, "R4 display off");
      do_read(A_DATA, 8'h07, "R4 R8 disabled readback");

      // R5 serial open-drain
      @(negedge clk); seg_en = 8'h00; ser_route = 1'b1; ser_en = 1'b1;
      chk_pins(8'h7C, 8'hFF, 8'h60, "R5 serial od");
      @(negedge clk); seg_en = 8'h40;
      chk_pins(8'h3C, 8'hBF, 8'h20, "R4 R5 priority");
      @(negedge clk); seg_en = 8'h00; ser_en = 1'b0;
      chk_pins(8'h3C, 8'hFF, 8'h00, "R5 enable low");
      @(negedge clk); ser_route = 1'b0;

      // R6 timer drive
      do_write(A_DIR, 8'h00);
      @(negedge clk); tmr_route = 1'b1; tmr_oc_en = 8'h04;
      chk_pins(8'h04, 8'hFF, 8'h00, "R6 one channel");
      @(negedge clk); tmr_oc_en = 8'hFF;
      chk_pins(8'h0C, 8'hFF, 8'h00, "R6 others ignored");
      do_read(A_DATA, 8'h07, "R6 R8 forced readback");
      @(negedge clk); tmr_route = 1'b0;
      chk_pins(8'h00, 8'hFF, 8'h00, "R6 route low");
      @(negedge clk); tmr_oc_en = 8'h00;

      // R9 two-stage synchronizer
      @(negedge clk); pad_in = 8'hA0;
      do_read(A_DATA, 8'h0F, "R9 not yet visible");
      do_read(A_DATA, 8'hA0, "R9 visible");

      repeat (3) @(negedge clk);
      summary();
      $finish;
   end

endmodule